// File: doc/BRIEF.md
# Protected Configuration Access Controller

This block sits between an external programming port and a device's non-volatile configuration. The configuration consists of a fuse word array, a 64-bit user signature held as eight bytes, and a bank of preloadable state registers. The port issues one command at a time with a request/ready handshake. Each command runs for a fixed number of busy cycles. It then completes with a one-cycle acknowledge, an error flag and read data.

A one-time security bit guards the array. Once it is programmed, the block refuses fuse verify reads and state register preloads. A refused verify returns zero data. Signature reads and writes stay open whatever the state of the bit. The lock applies from the command that follows the one that set it. Only a full erase clears the bit, and that erase also wipes the fuses and the signature.

Top module: `cfg_access_ctrl`

## Requirements
- R1: After reset, ready_o is 1, ack_o, err_o and rdata_o are 0, preload_o is all zero and the security bit is clear.
- R2: A command is accepted on a clock edge where req_i and ready_o are both 1. ready_o is 0 from the next cycle. ack_o pulses high for exactly one cycle, BUSY_CYCLES edges after the accepting edge (3 by default). ready_o is 1 again in the cycle of ack_o.
- R3: A request raised while ready_o is 0 is ignored: it produces no acknowledge and changes no state.
- R4: Opcode 0 writes wdata_i into fuse word addr_i. Opcode 1 returns fuse word addr_i on rdata_o with err_o 0 while unlocked.
- R5: Opcode 2 loads wdata_i into state register addr_i[2:0], shown on preload_o bits [8*k+7:8*k] for register k.
- R6: Opcode 3 writes signature byte addr_i[2:0]. Opcode 4 returns that byte on rdata_o.
- R7: Opcode 5 programs the security bit. From the next command on, opcode 1 completes with err_o 1 and rdata_o 0, while opcode 0 still writes.
- R8: While locked, opcode 2 completes with err_o 1 and preload_o keeps its value.
- R9: Opcodes 3 and 4 work the same way locked or unlocked, with err_o 0.
- R10: Opcode 6 clears every fuse word, every signature byte and the security bit. It leaves preload_o unchanged and completes with err_o 0.
- R11: Opcode 7 is invalid. It completes with err_o 1 and rdata_o 0 and changes nothing.
- R12: Repeating opcode 5 keeps the block locked. The security bit is set only by opcode 5 and cleared only by opcode 6.
- R13: Every command other than a permitted opcode 1 or 4 returns rdata_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Command request |
| op_i | input | 3 | Opcode |
| addr_i | input | ADDR_W (4) | Fuse word, signature byte or register index |
| wdata_i | input | DATA_W (8) | Write data |
| ready_o | output | 1 | Idle, able to accept a command |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Command refused, valid with ack_o |
| rdata_o | output | DATA_W (8) | Read data, valid with ack_o |
| preload_o | output | PRE_REGS*DATA_W (64) | Contents of the preloadable state registers |

## Verification
The bench locks the block and then checks four things: a verify is refused with zero data, a preload leaves the register bank as it was, and signature reads and writes still go through. A design that checked the lock on signature access would flag errors there. A design that checked only the verify path would let the preload overwrite state. A lock is issued twice and then erased, to show that the lock persists and that erase releases it. After the erase, reads return cleared data and preloads are allowed again. A request raised in the middle of a busy command tries to lock the block. If that request were not ignored, it would produce an extra acknowledge or refuse the later verify. The latency of every acknowledge is measured, so an off-by-one busy counter shows up.

// File: rtl/cfg_acc_pkg.sv
package cfg_acc_pkg;
  typedef enum logic [2:0] {
    OP_FPROG   = 3'd0,
    OP_FVERIFY = 3'd1,
    OP_PRELOAD = 3'd2,
    OP_SIG_WR  = 3'd3,
    OP_SIG_RD  = 3'd4,
    OP_LOCK    = 3'd5,
    OP_ERASE   = 3'd6,
    OP_BAD     = 3'd7
  } op_e;
endpackage

// File: rtl/cfg_acc_gate.sv
module cfg_acc_gate
  import cfg_acc_pkg::*;
(
  input  op_e  op_i,
  input  logic locked_i,
  output logic refuse_o
);
  always_comb begin
    case (op_i)
      OP_FVERIFY, OP_PRELOAD: refuse_o = locked_i;
      OP_BAD:                 refuse_o = 1'b1;
      default:                refuse_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_acc_seq.sv
module cfg_acc_seq
  import cfg_acc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              refuse_i,
  input  logic [DATA_W-1:0] rd_i,
  output logic              ready_o,
  output logic              ack_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              exec_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign ready_o = !busy_q;
  assign accept  = req_i && !busy_q;
  assign exec_o  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      op_o    <= OP_FPROG;
      addr_o  <= '0;
      wdata_o <= '0;
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        cnt_q   <= CNT_W'(BUSY_CYCLES - 1);
        op_o    <= op_e'(op_i);
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end else if (exec_o) begin
        busy_q  <= 1'b0;
        ack_o   <= 1'b1;
        err_o   <= refuse_i;
        rdata_o <= refuse_i ? '0 : rd_i;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r2_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);
  a_r2_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r2_ack_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ready_o);
endmodule

// File: rtl/cfg_acc_store.sv
module cfg_acc_store
  import cfg_acc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int SIG_BYTES = 8,
  parameter int PRE_REGS  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       exec_i,
  input  logic                       refuse_i,
  input  op_e                        op_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rd_o,
  output logic                       locked_o,
  output logic [PRE_REGS*DATA_W-1:0] preload_o
);
  localparam int FUSE_WORDS = 1 << ADDR_W;
  localparam int SIG_IDX_W  = $clog2(SIG_BYTES);
  localparam int PRE_IDX_W  = $clog2(PRE_REGS);

  logic [DATA_W-1:0] fuse_q [FUSE_WORDS];
  logic [DATA_W-1:0] sig_q  [SIG_BYTES];
  logic [DATA_W-1:0] pre_q  [PRE_REGS];
  logic              locked_q;
  logic              wr;
  logic [SIG_IDX_W-1:0] sig_idx;
  logic [PRE_IDX_W-1:0] pre_idx;

  assign wr       = exec_i && !refuse_i;
  assign sig_idx  = addr_i[SIG_IDX_W-1:0];
  assign pre_idx  = addr_i[PRE_IDX_W-1:0];
  assign locked_o = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FUSE_WORDS; i++) fuse_q[i] <= '0;
      for (int i = 0; i < SIG_BYTES; i++)  sig_q[i]  <= '0;
      for (int i = 0; i < PRE_REGS; i++)   pre_q[i]  <= '0;
      locked_q <= 1'b0;
    end else if (wr) begin
      case (op_i)
        OP_FPROG:   fuse_q[addr_i]  <= wdata_i;
        OP_PRELOAD: pre_q[pre_idx]  <= wdata_i;
        OP_SIG_WR:  sig_q[sig_idx]  <= wdata_i;
        OP_LOCK:    locked_q        <= 1'b1;
        OP_ERASE: begin
          for (int i = 0; i < FUSE_WORDS; i++) fuse_q[i] <= '0;
          for (int i = 0; i < SIG_BYTES; i++)  sig_q[i]  <= '0;
          locked_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (op_i)
      OP_FVERIFY: rd_o = fuse_q[addr_i];
      OP_SIG_RD:  rd_o = sig_q[sig_idx];
      default:    rd_o = '0;
    endcase
  end

  for (genvar g = 0; g < PRE_REGS; g++) begin : g_pre
    assign preload_o[g*DATA_W +: DATA_W] = pre_q[g];
  end

  a_r12_lock_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(exec_i && op_i == OP_LOCK));
  a_r12_unlock_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $past(exec_i && op_i == OP_ERASE));
  a_r8_preload_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && locked_q && op_i == OP_PRELOAD) |=> $stable(preload_o));
  a_r10_erase_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_ERASE) |=> !locked_q);
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_acc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SIG_BYTES   = 8,
  parameter int PRE_REGS    = 8,
  parameter int BUSY_CYCLES = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [2:0]                 op_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic                       ready_o,
  output logic                       ack_o,
  output logic                       err_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [PRE_REGS*DATA_W-1:0] preload_o
);
  logic              exec, refuse, locked;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd;

  cfg_acc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk_i, .rst_ni, .req_i, .op_i, .addr_i, .wdata_i,
    .refuse_i(refuse), .rd_i(rd),
    .ready_o, .ack_o, .err_o, .rdata_o,
    .exec_o(exec), .op_o(op_q), .addr_o(addr_q), .wdata_o(wdata_q)
  );

  cfg_acc_gate u_gate (.op_i(op_q), .locked_i(locked), .refuse_o(refuse));

  cfg_acc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_BYTES(SIG_BYTES),
                  .PRE_REGS(PRE_REGS)) u_store (
    .clk_i, .rst_ni, .exec_i(exec), .refuse_i(refuse), .op_i(op_q),
    .addr_i(addr_q), .wdata_i(wdata_q),
    .rd_o(rd), .locked_o(locked), .preload_o
  );

  a_r7_refused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && err_o) |-> (rdata_o == '0));
  a_r9_sig_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && (op_q == OP_SIG_RD || op_q == OP_SIG_WR)) |=> (ack_o && !err_o));
endmodule

// File: tb/sim_cfg_access_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_access_ctrl;
  localparam int BUSY = 3;

  typedef struct {
    logic        err;
    logic [7:0]  rdata;
    logic [63:0] pre;
    int          stamp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, ack, err;
  logic [7:0]  rdata;
  logic [63:0] pre;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  exp_t q[$];

  logic [7:0]  fuse_m [16];
  logic [7:0]  sig_m  [8];
  logic [63:0] pre_m = '0;
  bit          lock_m = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_access_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .ack_o(ack), .err_o(err),
    .rdata_o(rdata), .preload_o(pre)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops expected results as acknowledges appear
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (q.size() == 0) begin
        chk(0, "R3 unexpected ack", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(err == e.err, {e.tag, " err"}, 64'(err), 64'(e.err));
        chk(rdata == e.rdata, {e.tag, " rdata"}, 64'(rdata), 64'(e.rdata));
        chk(pre == e.pre, {e.tag, " preload"}, pre, e.pre);
        chk(cyc - e.stamp == BUSY + 1, "R2 ack latency",
            64'(cyc - e.stamp), 64'(BUSY + 1));
        chk(ready == 1'b1, "R2 ready with ack", 64'(ready), 1);
      end
    end
  end

  // Driver: predicts the result, pushes it, then runs the handshake
  task automatic send(logic [2:0] o, logic [3:0] a, logic [7:0] d, string tag,
                      bit intrude = 0);
    exp_t e;
    e.err = 0;
    e.rdata = '0;
    case (o)
      3'd0: fuse_m[a] = d;
      3'd1: if (lock_m) e.err = 1; else e.rdata = fuse_m[a];
      3'd2: if (lock_m) e.err = 1; else pre_m[a[2:0]*8 +: 8] = d;
      3'd3: sig_m[a[2:0]] = d;
      3'd4: e.rdata = sig_m[a[2:0]];
      3'd5: lock_m = 1;
      3'd6: begin
        foreach (fuse_m[i]) fuse_m[i] = '0;
        foreach (sig_m[i]) sig_m[i] = '0;
        lock_m = 0;
      end
      default: e.err = 1;
    endcase
    e.pre = pre_m;
    e.tag = tag;
    while (!ready) @(negedge clk);
    e.stamp = cyc;
    q.push_back(e);
    req = 1; op = o; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    chk(ready == 1'b0, "R2 ready low while busy", 64'(ready), 0);
    if (intrude) begin
      @(negedge clk);
      req = 1; op = 3'd5; addr = '0; wdata = '0;
      @(negedge clk);
      req = 0;
    end
    do @(negedge clk); while (!ack);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    foreach (fuse_m[i]) fuse_m[i] = '0;
    foreach (sig_m[i]) sig_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready == 1, "R1 reset ready", 64'(ready), 1);
    chk(ack == 0, "R1 reset ack", 64'(ack), 0);
    chk(err == 0, "R1 reset err", 64'(err), 0);
    chk(rdata == 0, "R1 reset rdata", 64'(rdata), 0);
    chk(pre == 0, "R1 reset preload", pre, 0);

    send(3'd0, 4'd3,  8'hA5, "R4 program word 3");
    send(3'd0, 4'd15, 8'h3C, "R4 program word 15");
    send(3'd1, 4'd3,  8'h00, "R4 verify word 3");
    send(3'd1, 4'd15, 8'h00, "R4 verify word 15");
    send(3'd1, 4'd0,  8'h00, "R4 verify blank word");
    send(3'd2, 4'd2,  8'h81, "R5 preload reg 2");
    send(3'd2, 4'd7,  8'hFF, "R5 preload reg 7");
    send(3'd3, 4'd0,  8'h11, "R6 signature write 0");
    send(3'd3, 4'd7,  8'hEE, "R6 signature write 7");
    send(3'd4, 4'd0,  8'h00, "R6 signature read 0");
    send(3'd4, 4'd7,  8'h00, "R6 signature read 7");
    send(3'd7, 4'd3,  8'h55, "R11 invalid opcode");
    send(3'd1, 4'd3,  8'h00, "R3 verify with busy intrusion", 1);
    send(3'd1, 4'd15, 8'h00, "R3 intrusion did not lock");
    send(3'd1, 4'd3,  8'h00, "R11 invalid changed nothing");

    send(3'd5, 4'd0,  8'h00, "R13 lock returns zero");
    send(3'd1, 4'd3,  8'h00, "R7 verify refused when locked");
    send(3'd0, 4'd4,  8'h77, "R7 program allowed when locked");
    send(3'd2, 4'd2,  8'h00, "R8 preload refused when locked");
    send(3'd4, 4'd7,  8'h00, "R9 signature read when locked");
    send(3'd3, 4'd1,  8'h22, "R9 signature write when locked");
    send(3'd4, 4'd1,  8'h00, "R9 signature readback when locked");
    send(3'd5, 4'd0,  8'h00, "R12 second lock");
    send(3'd1, 4'd15, 8'h00, "R12 still locked");

    send(3'd6, 4'd0,  8'h00, "R10 erase");
    send(3'd1, 4'd3,  8'h00, "R10 fuse cleared and unlocked");
    send(3'd1, 4'd4,  8'h00, "R10 locked-era word cleared");
    send(3'd4, 4'd0,  8'h00, "R10 signature cleared");
    send(3'd2, 4'd0,  8'h5A, "R12 preload allowed after erase");
    send(3'd0, 4'd9,  8'hC3, "R13 program returns zero");
    send(3'd1, 4'd9,  8'h00, "R4 verify after erase");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3 pending results", 64'(q.size()), 0);
    done = 1;
    finish_run();
  end
endmodule